// File: doc/BRIEF.md
# Multicast Cell Ingress Controller

This block sits at one input of a cell switch. It takes fixed-size cells from the head of an external input FIFO. Each head-of-line cell's connection key is looked up in a small local routing table. The table returns a bitmap of destination output groups and a call number that identifies the connection inside the switch. A cell that hits is tagged with both values and kept in a single-cell holding register. The block then shifts the tagged cell out serially, one bit per clock, toward the distribution fabric.

After each serial frame the fabric returns one acknowledge line per output group. Groups that acknowledge are removed from the held bitmap. If any requested group is still outstanding, the held cell is sent again, and the new frame carries only the remaining groups. When no group is left, the block fetches the next cell. A cell whose key matches no valid table entry is consumed without being sent, and a one-cycle miss pulse is raised. Table entries are written through a simple indexed write port.

Top module: `mcast_ingress_ctl`

## Requirements
- R1: `fifo_pop` is high only in a cycle where `fifo_empty` is low and no cell is held, and never while a frame is being shifted out; each cell is popped exactly once.
- R2: The lookup key is `fifo_cell[CELL_W-1-KEY_OFS -: KEY_W]` (bits 419 down to 396 by default). It matches a valid table entry with an equal key. When several valid entries match, the lowest index wins.
- R3: A frame is GROUPS+CALL_W+CELL_W bits, sent MSB first as {pending group bitmap, call number, cell}. `ser_valid` stays high for every bit without a gap, and `ser_sof` is high on the first bit only.
- R4: For a cell that hits, the first frame bit (with `ser_sof`) appears two cycles after the cycle in which it was popped.
- R5: On a miss the cell is popped, `miss_pulse` is high in that same pop cycle, and no frame is sent.
- R6: `fb_ack` is sampled in the cycle right after the last frame bit, during which `ser_valid` is low. Groups whose bit is 1 are cleared. If any requested group remains, a retry frame with the same call number and cell and only the remaining groups starts two cycles after that feedback cycle.
- R7: When no requested group remains after feedback, the block is idle in the next cycle and pops a waiting cell in that cycle.
- R8: `fb_ack` bits for groups that are not pending have no effect on the retry bitmap.
- R9: A hit whose group bitmap is all zero pops the cell, raises no miss and sends no frame.
- R10: A table write takes effect from the next cycle, so a lookup in the same cycle as the write sees the old contents. Reset marks every entry invalid.
- R11: While reset is asserted, `ser_valid`, `ser_sof`, `miss_pulse` and `fifo_pop` (with the FIFO empty) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_cell | input | CELL_W (424) | Cell at the head of the input FIFO |
| fifo_empty | input | 1 | Input FIFO holds no cell |
| fifo_pop | output | 1 | Remove the head cell at this clock edge |
| tbl_wr_en | input | 1 | Write one routing table entry |
| tbl_wr_idx | input | TBL_IDX_W (4) | Entry index to write |
| tbl_wr_key | input | KEY_W (24) | Connection key of the entry |
| tbl_wr_valid | input | 1 | Entry valid bit |
| tbl_wr_pat | input | GROUPS (4) | Destination group bitmap |
| tbl_wr_call | input | CALL_W (8) | Call number |
| fb_ack | input | GROUPS (4) | Per-group acceptance from the fabric |
| ser_data | output | 1 | Serial frame bit |
| ser_valid | output | 1 | Serial bit is valid |
| ser_sof | output | 1 | First bit of a frame |
| miss_pulse | output | 1 | Head cell matched no entry and was dropped |

## Verification
A table write and a head-of-line lookup can fall in the same cycle, and they can even target the key being looked up. The bench provokes this by pushing a cell with an unknown key at the same clock edge at which it writes a matching entry. It expects a miss and no frame for that cell, and then a normal frame for an identical cell pushed afterwards. A second coincidence is the end of delivery and a waiting cell. Here the bench queues two cells and requires the second pop in the cycle right after the feedback cycle.

// File: rtl/mcast_ingress_pkg.sv
package mcast_ingress_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOAD   = 2'd1,
      ST_SHIFT  = 2'd2,
      ST_FEEDBK = 2'd3
   } ingress_state_e;

   function automatic int idx_width(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/mcast_route_table.sv
module mcast_route_table #(
   parameter int DEPTH  = 16,
   parameter int KEY_W  = 24,
   parameter int GROUPS = 4,
   parameter int CALL_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic              wr_valid,
   input  logic [GROUPS-1:0] wr_pat,
   input  logic [CALL_W-1:0] wr_call,
   input  logic [KEY_W-1:0]  lk_key,
   output logic              lk_hit,
   output logic [GROUPS-1:0] lk_pat,
   output logic [CALL_W-1:0] lk_call
);

   logic [KEY_W-1:0]  key_q  [DEPTH];
   logic [GROUPS-1:0] pat_q  [DEPTH];
   logic [CALL_W-1:0] call_q [DEPTH];
   logic [DEPTH-1:0]  vld_q;
   logic [DEPTH-1:0]  match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int e = 0; e < DEPTH; e++) begin
            key_q[e]  <= '0;
            pat_q[e]  <= '0;
            call_q[e] <= '0;
         end
      end else if (wr_en) begin
         for (int e = 0; e < DEPTH; e++) begin
            if (wr_idx == IDX_W'(e)) begin
               key_q[e]  <= wr_key;
               pat_q[e]  <= wr_pat;
               call_q[e] <= wr_call;
               vld_q[e]  <= wr_valid;
            end
         end
      end
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
         assign match[g] = vld_q[g] && (key_q[g] == lk_key);
      end
   endgenerate

   // lowest index wins: scan from the top so lower entries overwrite
   always_comb begin
      lk_hit  = 1'b0;
      lk_pat  = '0;
      lk_call = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) begin
            lk_hit  = 1'b1;
            lk_pat  = pat_q[i];
            lk_call = call_q[i];
         end
      end
   end

endmodule

// File: rtl/mcast_hold_buffer.sv
module mcast_hold_buffer #(
   parameter int CELL_W  = 424,
   parameter int GROUPS  = 4,
   parameter int CALL_W  = 8,
   parameter int FRAME_W = GROUPS + CALL_W + CELL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic [CELL_W-1:0]  cap_cell,
   input  logic [GROUPS-1:0]  cap_pat,
   input  logic [CALL_W-1:0]  cap_call,
   input  logic               fb_apply,
   input  logic [GROUPS-1:0]  fb_ack,
   output logic [FRAME_W-1:0] frame,
   output logic               pend_left
);

   logic [CELL_W-1:0] cell_q;
   logic [GROUPS-1:0] pat_q;
   logic [CALL_W-1:0] call_q;
   logic [GROUPS-1:0] pat_after_fb;

   assign pat_after_fb = pat_q & ~fb_ack;
   assign pend_left    = |pat_after_fb;
   assign frame        = {pat_q, call_q, cell_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cell_q <= '0;
         pat_q  <= '0;
         call_q <= '0;
      end else if (capture) begin
         cell_q <= cap_cell;
         pat_q  <= cap_pat;
         call_q <= cap_call;
      end else if (fb_apply) begin
         pat_q  <= pat_after_fb;
      end
   end

endmodule

// File: rtl/mcast_cell_serializer.sv
module mcast_cell_serializer #(
   parameter int FRAME_W   = 436,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   output logic               sdata,
   output logic               svalid,
   output logic               ssof,
   output logic               slast
);

   localparam int CNT_W = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] sh_q;
   logic [FRAME_W-1:0] sh_next;
   logic [CNT_W-1:0]   left_q;
   logic               first_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign sdata   = sh_q[0];
         assign sh_next = sh_q >> 1;
      end else begin : g_msb
         assign sdata   = sh_q[FRAME_W-1];
         assign sh_next = sh_q << 1;
      end
   endgenerate

   assign svalid = (left_q != '0);
   assign ssof   = first_q && svalid;
   assign slast  = (left_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         left_q  <= '0;
         first_q <= 1'b0;
      end else if (load) begin
         sh_q    <= frame;
         left_q  <= CNT_W'(FRAME_W);
         first_q <= 1'b1;
      end else if (svalid) begin
         sh_q    <= sh_next;
         left_q  <= left_q - CNT_W'(1);
         first_q <= 1'b0;
      end
   end

endmodule

// File: rtl/mcast_ingress_fsm.sv
module mcast_ingress_fsm
   import mcast_ingress_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_empty,
   input  logic lk_hit,
   input  logic lk_pat_any,
   input  logic ser_last,
   input  logic pend_left,
   output logic fifo_pop,
   output logic miss,
   output logic capture,
   output logic ser_load,
   output logic fb_apply
);

   ingress_state_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      fifo_pop = 1'b0;
      miss     = 1'b0;
      capture  = 1'b0;
      ser_load = 1'b0;
      fb_apply = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (!fifo_empty) begin
               fifo_pop = 1'b1;
               miss     = !lk_hit;
               capture  = lk_hit && lk_pat_any;
               if (capture) state_d = ST_LOAD;
            end
         end
         ST_LOAD: begin
            ser_load = 1'b1;
            state_d  = ST_SHIFT;
         end
         ST_SHIFT: begin
            if (ser_last) state_d = ST_FEEDBK;
         end
         ST_FEEDBK: begin
            fb_apply = 1'b1;
            state_d  = pend_left ? ST_LOAD : ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/mcast_ingress_ctl.sv
module mcast_ingress_ctl #(
   parameter int CELL_BYTES = 53,
   parameter int GROUPS     = 4,
   parameter int TBL_DEPTH  = 16,
   parameter int KEY_W      = 24,
   parameter int KEY_OFS    = 4,
   parameter int CALL_W     = 8,
   parameter bit LSB_FIRST  = 1'b0,
   localparam int CELL_W    = 8 * CELL_BYTES,
   localparam int FRAME_W   = GROUPS + CALL_W + CELL_W,
   localparam int TBL_IDX_W = mcast_ingress_pkg::idx_width(TBL_DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CELL_W-1:0]    fifo_cell,
   input  logic                 fifo_empty,
   output logic                 fifo_pop,
   input  logic                 tbl_wr_en,
   input  logic [TBL_IDX_W-1:0] tbl_wr_idx,
   input  logic [KEY_W-1:0]     tbl_wr_key,
   input  logic                 tbl_wr_valid,
   input  logic [GROUPS-1:0]    tbl_wr_pat,
   input  logic [CALL_W-1:0]    tbl_wr_call,
   input  logic [GROUPS-1:0]    fb_ack,
   output logic                 ser_data,
   output logic                 ser_valid,
   output logic                 ser_sof,
   output logic                 miss_pulse
);

   generate
      if (GROUPS < 1 || GROUPS > 32) begin : g_bad_groups
         $error("GROUPS must lie in 1..32");
      end
      if (TBL_DEPTH < 2) begin : g_bad_depth
         $error("TBL_DEPTH must be at least 2");
      end
      if (KEY_OFS + KEY_W > CELL_W) begin : g_bad_key
         $error("key field exceeds the cell");
      end
      if (CALL_W < 1) begin : g_bad_call
         $error("CALL_W must be positive");
      end
   endgenerate

   logic [KEY_W-1:0]   lk_key;
   logic               lk_hit;
   logic [GROUPS-1:0]  lk_pat;
   logic [CALL_W-1:0]  lk_call;
   logic               capture;
   logic               ser_load;
   logic               ser_last;
   logic               fb_apply;
   logic               pend_left;
   logic [FRAME_W-1:0] frame;

   assign lk_key = fifo_cell[CELL_W-1-KEY_OFS -: KEY_W];

   mcast_route_table #(
      .DEPTH (TBL_DEPTH),
      .KEY_W (KEY_W),
      .GROUPS(GROUPS),
      .CALL_W(CALL_W),
      .IDX_W (TBL_IDX_W)
   ) table_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr_en),
      .wr_idx  (tbl_wr_idx),
      .wr_key  (tbl_wr_key),
      .wr_valid(tbl_wr_valid),
      .wr_pat  (tbl_wr_pat),
      .wr_call (tbl_wr_call),
      .lk_key  (lk_key),
      .lk_hit  (lk_hit),
      .lk_pat  (lk_pat),
      .lk_call (lk_call)
   );

   mcast_ingress_fsm fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_empty(fifo_empty),
      .lk_hit    (lk_hit),
      .lk_pat_any(|lk_pat),
      .ser_last  (ser_last),
      .pend_left (pend_left),
      .fifo_pop  (fifo_pop),
      .miss      (miss_pulse),
      .capture   (capture),
      .ser_load  (ser_load),
      .fb_apply  (fb_apply)
   );

   mcast_hold_buffer #(
      .CELL_W (CELL_W),
      .GROUPS (GROUPS),
      .CALL_W (CALL_W),
      .FRAME_W(FRAME_W)
   ) hold_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .cap_cell (fifo_cell),
      .cap_pat  (lk_pat),
      .cap_call (lk_call),
      .fb_apply (fb_apply),
      .fb_ack   (fb_ack),
      .frame    (frame),
      .pend_left(pend_left)
   );

   mcast_cell_serializer #(
      .FRAME_W  (FRAME_W),
      .LSB_FIRST(LSB_FIRST)
   ) ser_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ser_load),
      .frame (frame),
      .sdata (ser_data),
      .svalid(ser_valid),
      .ssof  (ser_sof),
      .slast (ser_last)
   );

endmodule

// File: rtl/mcast_ingress_chk.sv
module mcast_ingress_chk #(
   parameter int FRAME_W = 436
) (
   input logic clk,
   input logic rst_n,
   input logic fifo_empty,
   input logic fifo_pop,
   input logic ser_valid,
   input logic ser_sof,
   input logic miss_pulse
);

   localparam int BC_W = $clog2(FRAME_W + 1) + 1;

   logic [BC_W-1:0] bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bit_cnt <= '0;
      else if (ser_sof)   bit_cnt <= BC_W'(1);
      else if (ser_valid) bit_cnt <= bit_cnt + BC_W'(1);
   end

   AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);  // R1

   AST_NO_POP_MID_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      ser_valid |-> !fifo_pop);  // R1

   AST_MISS_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
      miss_pulse |-> fifo_pop);  // R5

   AST_MISS_NO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      miss_pulse |=> !ser_valid);  // R5

   AST_SOF_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      ser_sof |-> ser_valid);  // R3

   AST_FRAME_OPENS_SOF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_valid) |-> ser_sof);  // R3

   AST_FRAME_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid && !ser_sof) |-> (bit_cnt < BC_W'(FRAME_W)));  // R3

   AST_FRAME_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_valid) |-> (bit_cnt == BC_W'(FRAME_W)));  // R3

   AST_FEEDBACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_valid) |=> !ser_valid);  // R6

endmodule

bind mcast_ingress_ctl mcast_ingress_chk #(.FRAME_W(FRAME_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .fifo_empty(fifo_empty),
   .fifo_pop  (fifo_pop),
   .ser_valid (ser_valid),
   .ser_sof   (ser_sof),
   .miss_pulse(miss_pulse)
);

// File: tb/mcast_ingress_ctl_tb.sv
module mcast_ingress_ctl_tb_top;

   localparam int CELL_W  = 424;
   localparam int GROUPS  = 4;
   localparam int CALL_W  = 8;
   localparam int KEY_W   = 24;
   localparam int KEY_OFS = 4;
   localparam int DEPTH   = 16;
   localparam int FRAME_W = GROUPS + CALL_W + CELL_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CELL_W-1:0] fifo_cell;
   logic              fifo_empty;
   logic              fifo_pop;
   logic              tbl_wr_en = 1'b0;
   logic [3:0]        tbl_wr_idx = '0;
   logic [KEY_W-1:0]  tbl_wr_key = '0;
   logic              tbl_wr_valid = 1'b0;
   logic [GROUPS-1:0] tbl_wr_pat = '0;
   logic [CALL_W-1:0] tbl_wr_call = '0;
   logic [GROUPS-1:0] fb_ack = '0;
   logic              ser_data, ser_valid, ser_sof, miss_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   // bench-side input FIFO
   logic [CELL_W-1:0] fmem [32];
   int wr_ptr = 0;
   int rd_ptr = 0;
   assign fifo_empty = (wr_ptr == rd_ptr);
   assign fifo_cell  = fmem[rd_ptr[4:0]];

   // bench-side routing table model
   logic [KEY_W-1:0]  m_key  [DEPTH];
   logic [GROUPS-1:0] m_pat  [DEPTH];
   logic [CALL_W-1:0] m_call [DEPTH];
   logic              m_vld  [DEPTH];

   always #5 clk = ~clk;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (fifo_pop) rd_ptr <= rd_ptr + 1;
   end

   mcast_ingress_ctl dut_i (
      .clk(clk), .rst_n(rst_n),
      .fifo_cell(fifo_cell), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_key(tbl_wr_key),
      .tbl_wr_valid(tbl_wr_valid), .tbl_wr_pat(tbl_wr_pat), .tbl_wr_call(tbl_wr_call),
      .fb_ack(fb_ack),
      .ser_data(ser_data), .ser_valid(ser_valid), .ser_sof(ser_sof),
      .miss_pulse(miss_pulse)
   );

   task automatic chk(input string tag, input logic [FRAME_W-1:0] act,
                      input logic [FRAME_W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [CELL_W-1:0] make_cell(input logic [KEY_W-1:0] key, input int seed);
      logic [CELL_W-1:0] c;
      for (int i = 0; i < CELL_W / 8; i++) c[i*8 +: 8] = 8'((seed * 37 + i * 11 + 5) & 255);
      c[CELL_W-1-KEY_OFS -: KEY_W] = key;
      return c;
   endfunction

   // R2: lowest valid matching index wins
   task automatic model_lookup(input logic [CELL_W-1:0] c, output bit hit,
                               output logic [GROUPS-1:0] pat, output logic [CALL_W-1:0] call);
      logic [KEY_W-1:0] k;
      k = c[CELL_W-1-KEY_OFS -: KEY_W];
      hit = 0; pat = '0; call = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (m_vld[i] && m_key[i] == k) begin hit = 1; pat = m_pat[i]; call = m_call[i]; end
   endtask

   task automatic tbl_write(input int idx, input logic [KEY_W-1:0] key, input bit vld,
                            input logic [GROUPS-1:0] pat, input logic [CALL_W-1:0] call);
      @(negedge clk);
      tbl_wr_en = 1; tbl_wr_idx = 4'(idx); tbl_wr_key = key;
      tbl_wr_valid = vld; tbl_wr_pat = pat; tbl_wr_call = call;
      @(negedge clk);
      tbl_wr_en = 0;
      m_key[idx] = key; m_vld[idx] = vld; m_pat[idx] = pat; m_call[idx] = call;
   endtask

   task automatic push(input logic [CELL_W-1:0] c);
      fmem[wr_ptr[4:0]] = c;
      wr_ptr++;
   endtask

   task automatic wait_pop(input string tag, output int pc);
      int w = 0;
      while (fifo_pop !== 1'b1 && w < 50) begin @(negedge clk); w++; end
      chk({tag, " R1 pop seen"}, FRAME_W'(fifo_pop), FRAME_W'(1));
      pc = cyc;
   endtask

   task automatic expect_frame(input string tag, input logic [FRAME_W-1:0] exp, output int sof_cyc);
      int w = 0;
      logic [FRAME_W-1:0] got = '0;
      bit gap = 0;
      bit popped = 0;
      while (ser_valid !== 1'b1 && w < 3000) begin @(negedge clk); w++; end
      chk({tag, " R3 sof on first bit"}, FRAME_W'(ser_sof), FRAME_W'(1));
      sof_cyc = cyc;
      for (int j = 0; j < FRAME_W; j++) begin
         if (j != 0) begin
            @(negedge clk);
            if (ser_sof !== 1'b0) gap = 1;
         end
         if (ser_valid !== 1'b1) gap = 1;
         if (fifo_pop !== 1'b0) popped = 1;
         got = {got[FRAME_W-2:0], ser_data};
      end
      chk({tag, " R3 contiguous frame"}, FRAME_W'(gap), FRAME_W'(0));
      chk({tag, " R1 no pop mid frame"}, FRAME_W'(popped), FRAME_W'(0));
      chk({tag, " R3 frame content"}, got, exp);
   endtask

   task automatic give_fb(input logic [GROUPS-1:0] v, output int fb_cyc);
      @(negedge clk);
      chk("R6 idle feedback cycle", FRAME_W'(ser_valid), FRAME_W'(0));
      fb_ack = v;
      fb_cyc = cyc;
      @(negedge clk);
      fb_ack = '0;
   endtask

   task automatic expect_quiet(input string tag, input int n);
      bit seen = 0;
      for (int i = 0; i < n; i++) begin
         if (ser_valid !== 1'b0) seen = 1;
         @(negedge clk);
      end
      chk(tag, FRAME_W'(seen), FRAME_W'(0));
   endtask

   // push one cell and check its miss/no-send behaviour in the pop cycle
   task automatic push_expect_drop(input string tag, input logic [CELL_W-1:0] c, input bit exp_miss);
      int pc;
      push(c);
      #1;
      wait_pop(tag, pc);
      chk({tag, " miss flag"}, FRAME_W'(miss_pulse), FRAME_W'(exp_miss));
      expect_quiet({tag, " no frame"}, 30);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      bit hit;
      logic [GROUPS-1:0] pat, rem;
      logic [CALL_W-1:0] call;
      logic [CELL_W-1:0] c, c2;
      int pc, sc, fc;

      for (int i = 0; i < DEPTH; i++) begin
         m_vld[i] = 0; m_key[i] = '0; m_pat[i] = '0; m_call[i] = '0;
      end

      // R11: reset state
      repeat (3) @(negedge clk);
      chk("R11 ser_valid in reset", FRAME_W'(ser_valid), FRAME_W'(0));
      chk("R11 ser_sof in reset", FRAME_W'(ser_sof), FRAME_W'(0));
      chk("R11 miss in reset", FRAME_W'(miss_pulse), FRAME_W'(0));
      chk("R11 pop in reset", FRAME_W'(fifo_pop), FRAME_W'(0));
      rst_n = 1;
      @(negedge clk);

      // R10: table empty after reset, so any key misses
      push_expect_drop("R10 empty table", make_cell(24'h00A001, 1), 1'b1);

      tbl_write(2,  24'h00A001, 1, 4'b1111, 8'h21);
      tbl_write(5,  24'h00B002, 1, 4'b0110, 8'h52);
      tbl_write(9,  24'h00C003, 1, 4'b0000, 8'h93);
      tbl_write(3,  24'h00D004, 1, 4'b1000, 8'h34);
      tbl_write(11, 24'h00D004, 1, 4'b0001, 8'hB4);

      // R3 R4 R7: sweep every non-empty group bitmap, full ack
      for (int p = 1; p < 16; p++) begin
         tbl_write(0, 24'h00E005, 1, 4'(p), 8'(128 + p));
         c = make_cell(24'h00E005, p);
         model_lookup(c, hit, pat, call);
         push(c);
         #1;
         wait_pop("R4 sweep", pc);
         expect_frame("R3 sweep", {pat, call, c}, sc);
         chk("R4 sof two cycles after pop", FRAME_W'(sc - pc), FRAME_W'(2));
         give_fb(4'b1111, fc);
         expect_quiet("R7 no resend after full ack", 8);
      end

      // R6 R8: sweep feedback patterns against two requested bitmaps
      for (int s = 0; s < 2; s++) begin
         for (int f = 0; f < 16; f++) begin
            c = make_cell(s == 0 ? 24'h00A001 : 24'h00B002, 40 + s * 16 + f);
            model_lookup(c, hit, pat, call);
            push(c);
            #1;
            wait_pop("R6 sweep", pc);
            expect_frame("R6 first send", {pat, call, c}, sc);
            give_fb(4'(f), fc);
            rem = pat & ~4'(f);
            if (rem != '0) begin
               expect_frame("R8 retry pending groups", {rem, call, c}, sc);
               chk("R6 retry starts two cycles after feedback", FRAME_W'(sc - fc), FRAME_W'(2));
               give_fb(4'b1111, fc);
            end
            expect_quiet("R6 done after all groups served", 6);
         end
      end

      // R2: duplicate key, lowest index first; then invalidate it
      c = make_cell(24'h00D004, 77);
      push(c); #1;
      wait_pop("R2 prio", pc);
      expect_frame("R2 lowest index wins", {4'b1000, 8'h34, c}, sc);
      give_fb(4'b1111, fc);
      tbl_write(3, 24'h00D004, 0, 4'b1000, 8'h34);
      c = make_cell(24'h00D004, 78);
      push(c); #1;
      wait_pop("R2 prio", pc);
      expect_frame("R2 invalid entry skipped", {4'b0001, 8'hB4, c}, sc);
      give_fb(4'b0001, fc);

      // R5: unknown key
      push_expect_drop("R5 miss", make_cell(24'h0FFFFF, 90), 1'b1);
      // R9: hit with empty bitmap
      push_expect_drop("R9 empty bitmap", make_cell(24'h00C003, 91), 1'b0);

      // R10: write and lookup of the same key in one cycle
      @(negedge clk);
      tbl_wr_en = 1; tbl_wr_idx = 4'd7; tbl_wr_key = 24'h00F006;
      tbl_wr_valid = 1; tbl_wr_pat = 4'b0011; tbl_wr_call = 8'h76;
      push(make_cell(24'h00F006, 92));
      #1;
      chk("R10 pop during write", FRAME_W'(fifo_pop), FRAME_W'(1));
      chk("R10 lookup sees old table", FRAME_W'(miss_pulse), FRAME_W'(1));
      @(negedge clk);
      tbl_wr_en = 0;
      m_key[7] = 24'h00F006; m_vld[7] = 1; m_pat[7] = 4'b0011; m_call[7] = 8'h76;
      expect_quiet("R10 dropped cell not sent", 20);
      c = make_cell(24'h00F006, 93);
      model_lookup(c, hit, pat, call);
      push(c); #1;
      wait_pop("R10 after write", pc);
      expect_frame("R10 write effective", {pat, call, c}, sc);
      give_fb(4'b0011, fc);

      // R7: two cells queued, second pop right after feedback
      c  = make_cell(24'h00B002, 100);
      c2 = make_cell(24'h00B002, 101);
      push(c); push(c2); #1;
      wait_pop("R7 b2b", pc);
      expect_frame("R7 first of two", {4'b0110, 8'h52, c}, sc);
      give_fb(4'b0110, fc);
      chk("R7 next pop right after feedback", FRAME_W'(fifo_pop), FRAME_W'(1));
      chk("R7 pop cycle", FRAME_W'(cyc - fc), FRAME_W'(1));
      pc = cyc;
      expect_frame("R7 second of two", {4'b0110, 8'h52, c2}, sc);
      chk("R4 second cell timing", FRAME_W'(sc - pc), FRAME_W'(2));
      give_fb(4'b0110, fc);
      expect_quiet("R7 idle after both", 6);
      chk("R1 every cell popped once", FRAME_W'(rd_ptr), FRAME_W'(wr_ptr));

      // R10: reset clears the table
      rst_n = 0;
      repeat (2) @(negedge clk);
      chk("R11 outputs low in reset", FRAME_W'({ser_valid, ser_sof, miss_pulse}), FRAME_W'(0));
      rst_n = 1;
      @(negedge clk);
      push_expect_drop("R10 reset invalidates", make_cell(24'h00A001, 110), 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule